// File: doc/BRIEF.md
# Event Crosspoint Router with Path Tracking

This block routes single-bit digital trigger events from a bank of input lines to a set of output lines. Each output selects one input as its source. Software-side logic writes routes and delay codes into a staged (shadow) map one output at a time. An apply strobe then copies the whole staged map into the active map in one clock edge. As a result, an output never sees a half-written map. Every accepted change to the effective map opens a fixed settle window. During that window all outputs are held low, and any event that would have passed is counted as a switch glitch.

For traceability the block publishes three values. The first is a path identifier per output, made of the selected source index above the output index. The second is an 8-bit rolling checksum over all path identifiers. The third is a route sequence number that steps on every effective map change. A switch counter counts applied staged maps. The delay code of each output travels with its route and can be frozen to its last-known-good value. A safe-lock input overrides the active map with a fixed safe map, where output o takes input o mod N_IN. A per-output disable mask silences individual failing outputs.

Events are plain level pins sampled every cycle, and configuration is a plain write strobe. No data stream flows through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `xr_event_router`

## Requirements
- R1: While reset is asserted, ev_out is 0, settle_busy is 0, and route_seq, switch_cnt and glitch_cnt are 0. Both the staged and the active map select input o mod N_IN for output o, and every delay code is 0.
- R2: Outside a settle window, ev_out[o] equals ev_in[source of o] as sampled at the previous rising edge, which is a latency of one register.
- R3: A staged write (cfg_we, with cfg_out_sel, cfg_src_sel and cfg_dly) changes nothing visible until an accepted apply. An accepted apply copies every staged route at once, and route_seq then steps by one on the following edge. An apply in the same cycle as a staged write copies the map as it stood before that write.
- R4: An update is an accepted apply or a change of safe_lock. After the edge that takes an update, settle_busy is high for exactly SETTLE_CYC cycles. ev_out is 0 for SETTLE_CYC+1 cycles, starting at the edge that takes the update.
- R5: An apply is accepted only when settle_busy is low. An apply while settle_busy is high is ignored and leaves the map, switch_cnt and route_seq unchanged. switch_cnt increments by one for each accepted apply.
- R6: On each edge where output events are suppressed by an update or by the settle window, glitch_cnt increments by one if any enabled output's routed input is high.
- R7: path_id holds output o in bits [o*PW +: PW], where PW = SEL_W+OUT_W. The source index occupies the upper SEL_W bits and o the lower OUT_W bits. map_hash starts from 0xA5 and, for o = 0 upward, is rotated left by one bit and XORed with path_id of output o, zero-extended.
- R8: When out_disable[o] is high at an edge, ev_out[o] is 0 after that edge, and that output does not count toward glitches.
- R9: While safe_lock is high (as registered), output o takes input o mod N_IN, and path_id and map_hash follow that safe map. Each change of safe_lock is an update that steps route_seq but not switch_cnt.
- R10: An accepted apply with dly_freeze high updates the routes but keeps every active delay code. Without dly_freeze the staged codes are copied together with the routes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_in | input | N_IN | Event input lines |
| cfg_we | input | 1 | Staged-map write strobe |
| cfg_out_sel | input | OUT_W | Output whose staged entry is written |
| cfg_src_sel | input | SEL_W | Source input for the staged entry |
| cfg_dly | input | DLY_W | Delay code for the staged entry |
| apply | input | 1 | Copy the staged map to the active map |
| safe_lock | input | 1 | Override routing with the fixed safe map |
| out_disable | input | N_OUT | Per-output force-low mask |
| dly_freeze | input | 1 | Keep active delay codes on apply |
| ev_out | output | N_OUT | Routed, registered events |
| path_id | output | N_OUT*PW | Per-output path identifiers |
| dly_code | output | N_OUT*DLY_W | Active per-output delay codes |
| map_hash | output | 8 | Checksum of the effective route map |
| route_seq | output | SEQ_W | Effective-map change sequence number |
| switch_cnt | output | CNT_W | Count of accepted applies |
| glitch_cnt | output | CNT_W | Count of suppressed-event cycles |
| settle_busy | output | 1 | Settle window in progress |

## Verification
Every result lands one edge after the stimulus that causes it. ev_out reflects inputs one edge later, and an update's effects on the map, path_id, map_hash, route_seq, switch_cnt and settle_busy all appear right after the edge that takes the update. glitch_cnt includes a suppressed cycle after that same edge. The bench drives inputs on the falling edge and runs its reference model on the pre-edge state. It then samples every output 1 ns after the next rising edge, so each comparison falls exactly one register after its cause. Settle-window length, apply-while-busy, same-cycle write-and-apply, and safe-lock toggles are driven directly, and random traffic mixes them further.

// File: rtl/xr_pkg.sv
package xr_pkg;
  localparam int HASH_W = 8;
  localparam logic [HASH_W-1:0] HASH_SEED = 8'hA5;

  // one step of the rolling route-map checksum
  function automatic logic [HASH_W-1:0] hash_step(input logic [HASH_W-1:0] h,
                                                  input logic [HASH_W-1:0] pid);
    return {h[HASH_W-2:0], h[HASH_W-1]} ^ pid;
  endfunction
endpackage

// File: rtl/xr_route_regs.sv
module xr_route_regs #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 4,
  parameter int DLY_W = 6,
  localparam int SEL_W = (N_IN  > 1) ? $clog2(N_IN)  : 1,
  localparam int OUT_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [OUT_W-1:0]       cfg_out_sel,
  input  logic [SEL_W-1:0]       cfg_src_sel,
  input  logic [DLY_W-1:0]       cfg_dly,
  input  logic                   apply_ok,
  input  logic                   dly_freeze,
  output logic [N_OUT*SEL_W-1:0] act_src,
  output logic [N_OUT*DLY_W-1:0] act_dly
);
  logic [SEL_W-1:0] sh_src [N_OUT];
  logic [DLY_W-1:0] sh_dly [N_OUT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int o = 0; o < N_OUT; o++) begin
        sh_src[o]                 <= SEL_W'(o % N_IN);
        sh_dly[o]                 <= '0;
        act_src[o*SEL_W +: SEL_W] <= SEL_W'(o % N_IN);
        act_dly[o*DLY_W +: DLY_W] <= '0;
      end
    end else begin
      for (int o = 0; o < N_OUT; o++) begin
        if (cfg_we && cfg_out_sel == OUT_W'(o)) begin
          sh_src[o] <= cfg_src_sel;
          sh_dly[o] <= cfg_dly;
        end
        if (apply_ok) act_src[o*SEL_W +: SEL_W] <= sh_src[o];
        if (apply_ok && !dly_freeze) act_dly[o*DLY_W +: DLY_W] <= sh_dly[o];
      end
    end
  end

  AST_FREEZE_HOLDS_DLY: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_ok && dly_freeze) |=> $stable(act_dly)); // R10
endmodule

// File: rtl/xr_settle_ctl.sv
module xr_settle_ctl #(
  parameter int SETTLE_CYC = 4,
  parameter int SEQ_W      = 8,
  parameter int CNT_W      = 16,
  localparam int CW        = $clog2(SETTLE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  logic             safe_lock,
  output logic             apply_ok,
  output logic             update,
  output logic             lock_q,
  output logic             busy,
  output logic [SEQ_W-1:0] route_seq,
  output logic [CNT_W-1:0] switch_cnt
);
  logic [CW-1:0] cnt;

  assign busy     = (cnt != '0);
  assign apply_ok = apply && !busy;
  assign update   = apply_ok || (safe_lock != lock_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      lock_q     <= 1'b0;
      route_seq  <= '0;
      switch_cnt <= '0;
    end else begin
      lock_q <= safe_lock;
      if (update)         cnt <= CW'(SETTLE_CYC);
      else if (cnt != '0) cnt <= cnt - 1'b1;
      if (update)   route_seq  <= route_seq + 1'b1;
      if (apply_ok) switch_cnt <= switch_cnt + 1'b1;
    end
  end

  AST_SETTLE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> busy); // R4
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> (route_seq == $past(route_seq) + 1'b1)); // R3
  AST_BUSY_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(switch_cnt)); // R5
endmodule

// File: rtl/xr_fabric.sv
module xr_fabric #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 4,
  parameter int CNT_W = 16,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        ev_in,
  input  logic [N_OUT*SEL_W-1:0] act_src,
  input  logic                   lock_q,
  input  logic [N_OUT-1:0]       out_disable,
  input  logic                   quiet,
  output logic [N_OUT*SEL_W-1:0] eff_src,
  output logic [N_OUT-1:0]       ev_out,
  output logic [CNT_W-1:0]       glitch_cnt
);
  logic [N_OUT-1:0] raw;

  for (genvar o = 0; o < N_OUT; o++) begin : g_lane
    logic [SEL_W-1:0] src;
    assign src = lock_q ? SEL_W'(o % N_IN) : act_src[o*SEL_W +: SEL_W];
    assign eff_src[o*SEL_W +: SEL_W] = src;
    assign raw[o] = (32'(src) < N_IN) && ev_in[src] && !out_disable[o];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_out     <= '0;
      glitch_cnt <= '0;
    end else begin
      ev_out <= quiet ? '0 : raw;
      if (quiet && (raw != '0)) glitch_cnt <= glitch_cnt + 1'b1;
    end
  end

  AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> (ev_out == '0)); // R4
  AST_GLITCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((glitch_cnt - $past(glitch_cnt)) <= CNT_W'(1))); // R6
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_out & $past(out_disable)) == '0)); // R8
endmodule

// File: rtl/xr_event_router.sv
module xr_event_router
  import xr_pkg::*;
#(
  parameter int N_IN       = 8,
  parameter int N_OUT      = 4,
  parameter int DLY_W      = 6,
  parameter int SETTLE_CYC = 4,
  parameter int SEQ_W      = 8,
  parameter int CNT_W      = 16,
  localparam int SEL_W = (N_IN  > 1) ? $clog2(N_IN)  : 1,
  localparam int OUT_W = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int PW    = SEL_W + OUT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        ev_in,
  input  logic                   cfg_we,
  input  logic [OUT_W-1:0]       cfg_out_sel,
  input  logic [SEL_W-1:0]       cfg_src_sel,
  input  logic [DLY_W-1:0]       cfg_dly,
  input  logic                   apply,
  input  logic                   safe_lock,
  input  logic [N_OUT-1:0]       out_disable,
  input  logic                   dly_freeze,
  output logic [N_OUT-1:0]       ev_out,
  output logic [N_OUT*PW-1:0]    path_id,
  output logic [N_OUT*DLY_W-1:0] dly_code,
  output logic [HASH_W-1:0]      map_hash,
  output logic [SEQ_W-1:0]       route_seq,
  output logic [CNT_W-1:0]       switch_cnt,
  output logic [CNT_W-1:0]       glitch_cnt,
  output logic                   settle_busy
);
  logic                   apply_ok, update, lock_q, busy;
  logic [N_OUT*SEL_W-1:0] act_src, eff_src;

  xr_settle_ctl #(.SETTLE_CYC(SETTLE_CYC), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .apply(apply), .safe_lock(safe_lock),
    .apply_ok(apply_ok), .update(update), .lock_q(lock_q), .busy(busy),
    .route_seq(route_seq), .switch_cnt(switch_cnt));

  xr_route_regs #(.N_IN(N_IN), .N_OUT(N_OUT), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_out_sel(cfg_out_sel),
    .cfg_src_sel(cfg_src_sel), .cfg_dly(cfg_dly), .apply_ok(apply_ok),
    .dly_freeze(dly_freeze), .act_src(act_src), .act_dly(dly_code));

  xr_fabric #(.N_IN(N_IN), .N_OUT(N_OUT), .CNT_W(CNT_W)) u_fab (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .act_src(act_src), .lock_q(lock_q),
    .out_disable(out_disable), .quiet(update || busy), .eff_src(eff_src),
    .ev_out(ev_out), .glitch_cnt(glitch_cnt));

  assign settle_busy = busy;

  for (genvar o = 0; o < N_OUT; o++) begin : g_pid
    assign path_id[o*PW +: PW] = {eff_src[o*SEL_W +: SEL_W], OUT_W'(o)};
  end

  always_comb begin
    logic [HASH_W-1:0] h, pz;
    h = HASH_SEED;
    for (int o = 0; o < N_OUT; o++) begin
      pz = '0;
      pz[PW-1:0] = path_id[o*PW +: PW];
      h = hash_step(h, pz);
    end
    map_hash = h;
  end

  AST_HASH_FOLLOWS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(path_id) |-> $stable(map_hash)); // R7
endmodule

// File: tb/xr_event_router_tb.sv
module xr_event_router_tb;
  localparam int NI = 8, NO = 4, DW = 6, SC = 4, PW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NI-1:0] ev_in = '0;
  logic cfg_we = 0, apply = 0, safe_lock = 0, dly_freeze = 0;
  logic [1:0] cfg_out_sel = '0;
  logic [2:0] cfg_src_sel = '0;
  logic [DW-1:0] cfg_dly = '0;
  logic [NO-1:0] out_disable = '0;
  logic [NO-1:0] ev_out;
  logic [NO*PW-1:0] path_id;
  logic [NO*DW-1:0] dly_code;
  logic [7:0] map_hash, route_seq;
  logic [15:0] switch_cnt, glitch_cnt;
  logic settle_busy;

  always #2 clk = ~clk;

  xr_event_router u_dut (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .cfg_we(cfg_we), .cfg_out_sel(cfg_out_sel),
    .cfg_src_sel(cfg_src_sel), .cfg_dly(cfg_dly), .apply(apply), .safe_lock(safe_lock),
    .out_disable(out_disable), .dly_freeze(dly_freeze), .ev_out(ev_out), .path_id(path_id),
    .dly_code(dly_code), .map_hash(map_hash), .route_seq(route_seq), .switch_cnt(switch_cnt),
    .glitch_cnt(glitch_cnt), .settle_busy(settle_busy));

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  int m_src[NO], m_dly[NO], s_src[NO], s_dly[NO];
  int m_cnt = 0, m_seq = 0, m_swc = 0, m_glc = 0;
  bit m_lock = 0;
  logic [NO-1:0] e_out = '0;
  string t_ev, t_seq, t_dly;

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff(int o);
    return m_lock ? (o % NI) : m_src[o];
  endfunction

  function automatic int exp_pid(int o);
    return (eff(o) << 2) | o;
  endfunction

  function automatic int exp_hash();
    logic [7:0] h = 8'hA5;
    for (int o = 0; o < NO; o++) h = {h[6:0], h[7]} ^ 8'(exp_pid(o));
    return int'(h);
  endfunction

  task automatic model_reset();
    for (int o = 0; o < NO; o++) begin
      m_src[o] = o % NI; s_src[o] = o % NI; m_dly[o] = 0; s_dly[o] = 0;
    end
    m_cnt = 0; m_seq = 0; m_swc = 0; m_glc = 0; m_lock = 0; e_out = '0;
  endtask

  task automatic model_step();
    bit busy, ap_ok, upd, quiet;
    logic [NO-1:0] raw;
    int os[NO], od[NO];
    busy = (m_cnt != 0);
    ap_ok = apply && !busy;
    upd = ap_ok || (safe_lock != m_lock);
    quiet = busy || upd;
    for (int o = 0; o < NO; o++) raw[o] = ev_in[eff(o)] && !out_disable[o];
    t_ev  = (out_disable != 0) ? "R8" : (m_lock ? "R9" : (quiet ? "R4" : "R2"));
    t_seq = (safe_lock != m_lock) ? "R9" : "R3";
    t_dly = dly_freeze ? "R10" : "R3";
    e_out = quiet ? '0 : raw;
    if (quiet && raw != 0) m_glc = (m_glc + 1) & 16'hFFFF;
    for (int o = 0; o < NO; o++) begin os[o] = s_src[o]; od[o] = s_dly[o]; end
    if (cfg_we) begin s_src[cfg_out_sel] = cfg_src_sel; s_dly[cfg_out_sel] = cfg_dly; end
    if (ap_ok) begin
      for (int o = 0; o < NO; o++) begin
        m_src[o] = os[o];
        if (!dly_freeze) m_dly[o] = od[o];
      end
      m_swc = (m_swc + 1) & 16'hFFFF;
    end
    if (upd) begin m_seq = (m_seq + 1) & 8'hFF; m_cnt = SC; end
    else if (m_cnt != 0) m_cnt--;
    m_lock = safe_lock;
  endtask

  task automatic compare_all();
    chk(t_ev, int'(ev_out), int'(e_out));
    chk("R4 busy", int'(settle_busy), int'(m_cnt != 0));
    chk(t_seq, int'(route_seq), m_seq);
    chk("R5 switch", int'(switch_cnt), m_swc);
    chk("R6 glitch", int'(glitch_cnt), m_glc);
    for (int o = 0; o < NO; o++) begin
      chk("R7 path", int'(path_id[o*PW +: PW]), exp_pid(o));
      chk(t_dly, int'(dly_code[o*DW +: DW]), m_dly[o]);
    end
    chk("R7 hash", int'(map_hash), exp_hash());
  endtask

  task automatic cyc(logic [NI-1:0] ev, bit we, int idx, int src, int dly,
                     bit ap, bit lk, logic [NO-1:0] dis, bit fz);
    @(negedge clk);
    ev_in = ev; cfg_we = we; cfg_out_sel = 2'(idx); cfg_src_sel = 3'(src);
    cfg_dly = DW'(dly); apply = ap; safe_lock = lk; out_disable = dis; dly_freeze = fz;
    model_step();
    @(posedge clk); #1;
    compare_all();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 ev_out", int'(ev_out), 0);
    chk("R1 busy", int'(settle_busy), 0);
    chk("R1 seq", int'(route_seq), 0);
    chk("R1 switch", int'(switch_cnt), 0);
    chk("R1 glitch", int'(glitch_cnt), 0);
    chk("R1 dly", int'(dly_code), 0);
    for (int o = 0; o < NO; o++) chk("R1 path", int'(path_id[o*PW +: PW]), exp_pid(o));
    chk("R1 hash", int'(map_hash), exp_hash());
    @(negedge clk); rst_n = 1'b1;

    // R2: safe default routing
    cyc(8'h0F, 0, 0, 0, 0, 0, 0, 4'h0, 0);
    cyc(8'h05, 0, 0, 0, 0, 0, 0, 4'h0, 0);
    // R3: staged write alone is invisible
    cyc(8'h20, 1, 2, 5, 9, 0, 0, 4'h0, 0);
    cyc(8'h20, 0, 0, 0, 0, 0, 0, 4'h0, 0);
    // R3/R4/R6: apply, then events during settle
    cyc(8'h20, 0, 0, 0, 0, 1, 0, 4'h0, 0);
    cyc(8'h20, 0, 0, 0, 0, 1, 0, 4'h0, 0);   // R5: apply while busy ignored
    for (int i = 0; i < SC + 2; i++) cyc(8'h20, 0, 0, 0, 0, 0, 0, 4'h0, 0);
    // R3: write and apply in the same cycle uses the old staged map
    cyc(8'h00, 1, 1, 7, 3, 1, 0, 4'h0, 0);
    for (int i = 0; i < SC + 1; i++) cyc(8'h80, 0, 0, 0, 0, 0, 0, 4'h0, 0);
    // R8: disable output 2
    cyc(8'h20, 0, 0, 0, 0, 0, 0, 4'h4, 0);
    cyc(8'h20, 0, 0, 0, 0, 0, 0, 4'h4, 0);
    // R9: safe lock on and off
    for (int i = 0; i < SC + 3; i++) cyc(8'hFF, 0, 0, 0, 0, 0, 1, 4'h0, 0);
    for (int i = 0; i < SC + 3; i++) cyc(8'hFF, 0, 0, 0, 0, 0, 0, 4'h0, 0);
    // R10: frozen delay codes
    cyc(8'h00, 1, 0, 6, 63, 0, 0, 4'h0, 0);
    cyc(8'h00, 0, 0, 0, 0, 1, 0, 4'h0, 1);
    for (int i = 0; i < SC + 1; i++) cyc(8'h40, 0, 0, 0, 0, 0, 0, 4'h0, 0);
    cyc(8'h00, 0, 0, 0, 0, 1, 0, 4'h0, 0);
    for (int i = 0; i < SC + 1; i++) cyc(8'h40, 0, 0, 0, 0, 0, 0, 4'h0, 0);

    // constrained random mix
    begin
      bit lk = 0;
      for (int i = 0; i < 2000; i++) begin
        logic [NI-1:0] ev = NI'($urandom & $urandom);
        logic [NO-1:0] dis = ($urandom % 10 == 0) ? NO'($urandom) : '0;
        if ($urandom % 80 == 0) lk = !lk;
        cyc(ev, bit'($urandom % 2), int'($urandom % NO), int'($urandom % NI),
            int'($urandom % 64), ($urandom % 6 == 0), lk, dis, ($urandom % 4 == 0));
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule